// File: doc/BRIEF.md
# NAND flash access phase timer

This block times a single access to a NAND flash device. A one-clock start request, sampled while the block is idle, opens the access. It carries a direction flag and a space select. The space select picks one of two timing sets: the common set or the attribute set. Each set has four counts: setup, strobe, hold and bus-release. A read also uses a short latch-to-read delay. All of these values are captured at the start edge, so the inputs may change freely while the access runs.

The controller moves through these states: `ST_IDLE`, `ST_TURN` (latch-to-read delay, reads only), `ST_SETUP`, `ST_STROBE` (programmed strobe time), `ST_STRETCH` (strobe held while the device reports not ready), `ST_HOLD` and `ST_DONE`.

The transitions are:
- `ST_IDLE` goes to `ST_TURN` on a read start, or to `ST_SETUP` on a write start.
- `ST_TURN` goes to `ST_SETUP` when its count expires.
- `ST_SETUP` goes to `ST_STROBE` when its count expires.
- `ST_STROBE` goes to `ST_STRETCH` if the wait input is low on its last cycle. Otherwise it goes to `ST_HOLD`, or straight to `ST_DONE` when the hold length is zero.
- `ST_STRETCH` goes to `ST_HOLD` or `ST_DONE` once wait is sampled high.
- `ST_HOLD` goes to `ST_DONE` when its count expires.
- `ST_DONE` always returns to `ST_IDLE`.

The block drives three outputs. A write strobe or a read strobe, both active low, goes to the device. A data-drive enable goes to the data pad for writes. A one-cycle done pulse goes back to the sequencer that issues command, address and data cycles. "Cycle k" below means the clock period that follows the k-th rising edge after the start edge, counting the start edge as edge 0.

Top module: `nand_phase_timer`

## Requirements
- R1: While reset is low, and in the first cycle after it, both strobes are high (inactive), the data-drive enable is low and done is low.
- R2: With space select high at the start edge, the attribute timing set is used; with it low, the common set is used. The set, the direction and the latch delay are all captured at the start edge, and later changes to those inputs have no effect on the running access.
- R3: On a write, the write strobe first goes low in cycle SET+1 (setup lasts SET+1 cycles).
- R4: On a read, the read strobe first goes low in cycle T+SET+2, where T is the 4-bit latch-to-read delay.
- R5: The strobe stays low for exactly STROBE+1 cycles when the wait input is high in its last programmed cycle; a low wait input earlier in the strobe has no effect.
- R6: If the wait input is low in the last programmed strobe cycle, the strobe stays low up to and including the first cycle in which wait is high again.
- R7: After the strobe is released, the hold phase lasts HOLD cycles on a write and HOLD+1 cycles on a read, so a write with HOLD=0 has no hold cycle.
- R8: On a write, the data-drive enable is low in cycles 0 to HIZ-1 and high from cycle HIZ up to the cycle before done. If HIZ reaches past the hold phase it is never high. It is never high during a read.
- R9: Done is high for exactly one cycle, the cycle after the hold phase ends. A start that is high while an access runs, or in the done cycle, is ignored. A new access can begin at the edge that ends the cycle after done.
- R10: At most one strobe is low at any time, and only the strobe that matches the captured direction ever goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Access request, taken only when idle |
| write_i | input | 1 | 1 = write, 0 = read |
| attr_i | input | 1 | 1 = attribute timing set, 0 = common set |
| turn_dly_i | input | TRW (4) | Latch-to-read delay T |
| com_setup_i | input | TW (8) | Common setup count |
| com_strobe_i | input | TW (8) | Common strobe count |
| com_hold_i | input | TW (8) | Common hold count |
| com_hiz_i | input | TW (8) | Common bus-release count |
| att_setup_i | input | TW (8) | Attribute setup count |
| att_strobe_i | input | TW (8) | Attribute strobe count |
| att_hold_i | input | TW (8) | Attribute hold count |
| att_hiz_i | input | TW (8) | Attribute bus-release count |
| wait_n_i | input | 1 | Device ready, low = stretch the strobe |
| we_n_o | output | 1 | Write strobe, active low |
| oe_n_o | output | 1 | Read strobe, active low |
| data_oe_o | output | 1 | Data pad drive enable, active high |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The checks assume that the wait input is already synchronous to the controller clock and changes only between edges. The bench meets this by driving wait on the falling edge, as a pure function of the cycle index of the running access. The checks also assume that start is a level that the block may ignore while it is busy. The bench therefore holds start high across a whole access, done cycle included, and drops it before the first idle edge, so that one request produces exactly one access. The timing inputs are scrambled right after each start edge, which keeps every check dependent on the captured copy alone.

// File: rtl/nand_timer_pkg.sv
package nand_timer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_STROBE,
        ST_STRETCH,
        ST_HOLD,
        ST_DONE
    } nt_state_e;

    localparam int unsigned NT_FIELDS = 4;
    localparam int unsigned NT_F_SETUP = 0;
    localparam int unsigned NT_F_STROBE = 1;
    localparam int unsigned NT_F_HOLD = 2;
    localparam int unsigned NT_F_HIZ = 3;

endpackage

// File: rtl/nt_down_counter.sv
module nt_down_counter #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);

    // The count never wraps: a zero count stays zero until it is loaded again.
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/nt_param_select.sv
module nt_param_select
    import nand_timer_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic          attr_i,
    input  logic          write_i,
    input  logic [TW-1:0] com_setup_i,
    input  logic [TW-1:0] com_strobe_i,
    input  logic [TW-1:0] com_hold_i,
    input  logic [TW-1:0] com_hiz_i,
    input  logic [TW-1:0] att_setup_i,
    input  logic [TW-1:0] att_strobe_i,
    input  logic [TW-1:0] att_hold_i,
    input  logic [TW-1:0] att_hiz_i,
    output logic [TW-1:0] live_setup_o,
    output logic [TW-1:0] live_hiz_o,
    output logic [TW-1:0] held_setup_o,
    output logic [TW-1:0] held_strobe_o,
    output logic [TW-1:0] held_hold_o,
    output logic          held_write_o
);
    // Fields at index NT_F_HIZ and above are only needed at the start edge.
    localparam int unsigned NHELD = NT_F_HIZ;

    logic [NT_FIELDS-1:0][TW-1:0] com_f;
    logic [NT_FIELDS-1:0][TW-1:0] att_f;
    logic [NT_FIELDS-1:0][TW-1:0] live_f;
    logic [NHELD-1:0][TW-1:0]     held_f;

    assign com_f = {com_hiz_i, com_hold_i, com_strobe_i, com_setup_i};
    assign att_f = {att_hiz_i, att_hold_i, att_strobe_i, att_setup_i};

    for (genvar g = 0; g < NT_FIELDS; g++) begin : g_field
        assign live_f[g] = attr_i ? att_f[g] : com_f[g];
        if (g < NHELD) begin : g_keep
            logic [TW-1:0] held_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    held_q <= '0;
                end else if (capture_i) begin
                    held_q <= live_f[g];
                end
            end
            assign held_f[g] = held_q;
        end
    end

    logic write_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            write_q <= 1'b0;
        end else if (capture_i) begin
            write_q <= write_i;
        end
    end

    assign live_setup_o  = live_f[NT_F_SETUP];
    assign live_hiz_o    = live_f[NT_F_HIZ];
    assign held_setup_o  = held_f[NT_F_SETUP];
    assign held_strobe_o = held_f[NT_F_STROBE];
    assign held_hold_o   = held_f[NT_F_HOLD];
    assign held_write_o  = write_q;

    // The captured values follow the set chosen by attr_i at the capture edge.
    a_r2_pick_set: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && attr_i) |=> (held_strobe_o == $past(att_strobe_i)));

endmodule

// File: rtl/nt_hiz_window.sv
module nt_hiz_window #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] hiz_i,
    input  logic          phase_i,
    output logic          data_oe_o
);
    logic released_over;

    nt_down_counter #(.W(TW)) i_hiz_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .value_i (hiz_i),
        .zero_o  (released_over)
    );

    assign data_oe_o = phase_i && released_over;

    // A non-zero release count keeps the pad undriven in the first access cycle.
    a_r8_release_first: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && hiz_i != '0) |=> !data_oe_o);

endmodule

// File: rtl/nt_phase_fsm.sv
module nt_phase_fsm
    import nand_timer_pkg::*;
#(
    parameter int unsigned TW  = 8,
    parameter int unsigned TRW = 4,
    parameter int unsigned CW  = TW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           write_i,
    input  logic           wait_n_i,
    input  logic [TW-1:0]  live_setup_i,
    input  logic [TRW-1:0] turn_i,
    input  logic [TW-1:0]  held_setup_i,
    input  logic [TW-1:0]  held_strobe_i,
    input  logic [TW-1:0]  held_hold_i,
    input  logic           held_write_i,
    input  logic           cnt_zero_i,
    output logic           cnt_load_o,
    output logic [CW-1:0]  cnt_value_o,
    output logic           capture_o,
    output logic           we_n_o,
    output logic           oe_n_o,
    output logic           done_o,
    output logic           drive_phase_o
);
    nt_state_e state_q, state_d;

    logic [CW-1:0] hold_len;
    logic [CW-1:0] hold_last;
    logic          hold_none;
    logic          strobe_on;

    // Reads keep the address one cycle longer after the strobe.
    assign hold_len  = CW'(held_hold_i) + CW'(!held_write_i);
    assign hold_last = hold_len - CW'(1);
    assign hold_none = (hold_len == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        cnt_load_o  = 1'b0;
        cnt_value_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    cnt_load_o = 1'b1;
                    if (write_i) begin
                        state_d     = ST_SETUP;
                        cnt_value_o = CW'(live_setup_i);
                    end else begin
                        state_d     = ST_TURN;
                        cnt_value_o = CW'(turn_i);
                    end
                end
            end
            ST_TURN: begin
                if (cnt_zero_i) begin
                    state_d     = ST_SETUP;
                    cnt_load_o  = 1'b1;
                    cnt_value_o = CW'(held_setup_i);
                end
            end
            ST_SETUP: begin
                if (cnt_zero_i) begin
                    state_d     = ST_STROBE;
                    cnt_load_o  = 1'b1;
                    cnt_value_o = CW'(held_strobe_i);
                end
            end
            ST_STROBE: begin
                if (cnt_zero_i) begin
                    if (!wait_n_i) begin
                        state_d = ST_STRETCH;
                    end else if (hold_none) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d     = ST_HOLD;
                        cnt_load_o  = 1'b1;
                        cnt_value_o = hold_last;
                    end
                end
            end
            ST_STRETCH: begin
                if (wait_n_i) begin
                    if (hold_none) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d     = ST_HOLD;
                        cnt_load_o  = 1'b1;
                        cnt_value_o = hold_last;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero_i) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        strobe_on     = (state_q == ST_STROBE) || (state_q == ST_STRETCH);
        we_n_o        = !(strobe_on && held_write_i);
        oe_n_o        = !(strobe_on && !held_write_i);
        done_o        = (state_q == ST_DONE);
        drive_phase_o = held_write_i && (state_q inside {ST_SETUP, ST_STROBE, ST_STRETCH, ST_HOLD});
        capture_o     = (state_q == ST_IDLE) && start_i;
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_done_ignores_start: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (state_q == ST_IDLE));

    a_r6_stretch_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on && cnt_zero_i && !wait_n_i) |=> strobe_on);

    a_r7_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> ($past(state_q) == ST_HOLD || $past(strobe_on)));

endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
    parameter int unsigned TW  = 8,
    parameter int unsigned TRW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           write_i,
    input  logic           attr_i,
    input  logic [TRW-1:0] turn_dly_i,
    input  logic [TW-1:0]  com_setup_i,
    input  logic [TW-1:0]  com_strobe_i,
    input  logic [TW-1:0]  com_hold_i,
    input  logic [TW-1:0]  com_hiz_i,
    input  logic [TW-1:0]  att_setup_i,
    input  logic [TW-1:0]  att_strobe_i,
    input  logic [TW-1:0]  att_hold_i,
    input  logic [TW-1:0]  att_hiz_i,
    input  logic           wait_n_i,
    output logic           we_n_o,
    output logic           oe_n_o,
    output logic           data_oe_o,
    output logic           done_o
);
    localparam int unsigned CW = TW + 1;

    logic          capture;
    logic          cnt_load;
    logic [CW-1:0] cnt_value;
    logic          cnt_zero;
    logic          drive_phase;
    logic [TW-1:0] live_setup;
    logic [TW-1:0] live_hiz;
    logic [TW-1:0] held_setup;
    logic [TW-1:0] held_strobe;
    logic [TW-1:0] held_hold;
    logic          held_write;

    nt_param_select #(.TW(TW)) i_params (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture_i     (capture),
        .attr_i        (attr_i),
        .write_i       (write_i),
        .com_setup_i   (com_setup_i),
        .com_strobe_i  (com_strobe_i),
        .com_hold_i    (com_hold_i),
        .com_hiz_i     (com_hiz_i),
        .att_setup_i   (att_setup_i),
        .att_strobe_i  (att_strobe_i),
        .att_hold_i    (att_hold_i),
        .att_hiz_i     (att_hiz_i),
        .live_setup_o  (live_setup),
        .live_hiz_o    (live_hiz),
        .held_setup_o  (held_setup),
        .held_strobe_o (held_strobe),
        .held_hold_o   (held_hold),
        .held_write_o  (held_write)
    );

    nt_down_counter #(.W(CW)) i_phase_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cnt_load),
        .value_i (cnt_value),
        .zero_o  (cnt_zero)
    );

    nt_phase_fsm #(.TW(TW), .TRW(TRW), .CW(CW)) i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .write_i       (write_i),
        .wait_n_i      (wait_n_i),
        .live_setup_i  (live_setup),
        .turn_i        (turn_dly_i),
        .held_setup_i  (held_setup),
        .held_strobe_i (held_strobe),
        .held_hold_i   (held_hold),
        .held_write_i  (held_write),
        .cnt_zero_i    (cnt_zero),
        .cnt_load_o    (cnt_load),
        .cnt_value_o   (cnt_value),
        .capture_o     (capture),
        .we_n_o        (we_n_o),
        .oe_n_o        (oe_n_o),
        .done_o        (done_o),
        .drive_phase_o (drive_phase)
    );

    nt_hiz_window #(.TW(TW)) i_hiz (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (capture),
        .hiz_i     (live_hiz),
        .phase_i   (drive_phase),
        .data_oe_o (data_oe_o)
    );

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n_o && !oe_n_o));

    a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> oe_n_o);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (we_n_o && oe_n_o && !done_o));

endmodule

// File: tb/test_nand_phase_timer.sv
module test_nand_phase_timer;
    localparam int CLK_PERIOD = 10;
    localparam int TW = 8;
    localparam int TRW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, write_i = 1'b0, attr_i = 1'b0, wait_n_i = 1'b1;
    logic [TRW-1:0] turn_dly_i = '0;
    logic [TW-1:0] com_setup_i = '0, com_strobe_i = '0, com_hold_i = '0, com_hiz_i = '0;
    logic [TW-1:0] att_setup_i = '0, att_strobe_i = '0, att_hold_i = '0, att_hiz_i = '0;
    logic we_n_o, oe_n_o, data_oe_o, done_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_phase_timer #(.TW(TW), .TRW(TRW)) i_nand_phase_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i), .attr_i(attr_i),
        .turn_dly_i(turn_dly_i),
        .com_setup_i(com_setup_i), .com_strobe_i(com_strobe_i), .com_hold_i(com_hold_i), .com_hiz_i(com_hiz_i),
        .att_setup_i(att_setup_i), .att_strobe_i(att_strobe_i), .att_hold_i(att_hold_i), .att_hiz_i(att_hiz_i),
        .wait_n_i(wait_n_i), .we_n_o(we_n_o), .oe_n_o(oe_n_o), .data_oe_o(data_oe_o), .done_o(done_o)
    );

    typedef struct {
        int s; int len; int d; int first_oe; int n_oe; bit wr;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    int acc_k = 0;
    bit active = 1'b0;
    int idle_bad = 0;
    bit ended = 1'b0;

    int m_s, m_len, m_wrong, m_oe, m_noe;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Monitor: samples one time unit after each rising edge and checks against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (active && q.size() > 0) begin
                if (acc_k == 0) begin
                    m_s = -1; m_len = 0; m_wrong = 0; m_oe = -1; m_noe = 0;
                end
                if (q[0].wr ? !we_n_o : !oe_n_o) begin
                    if (m_s < 0) m_s = acc_k;
                    m_len++;
                end
                if (q[0].wr ? !oe_n_o : !we_n_o) m_wrong++;
                if (data_oe_o) begin
                    if (m_oe < 0) m_oe = acc_k;
                    m_noe++;
                end
                if (done_o) begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.wr ? "R3" : "R4", "strobe start cycle", m_s, e.s);
                    chk("R5/R6 (R5 R6)", "strobe length", m_len, e.len);
                    chk("R7", "done cycle", acc_k, e.d);
                    chk("R8", "first driven cycle", m_oe, e.first_oe);
                    chk("R8", "driven cycles", m_noe, e.n_oe);
                    chk("R10", "wrong strobe cycles", m_wrong, 0);
                end
            end else if (rst_n && (!we_n_o || !oe_n_o || done_o || data_oe_o)) begin
                idle_bad++;
            end
        end
    end

    // Driver: sets both timing sets, pushes the expected item, runs one access.
    task automatic run_acc(bit wr, bit at, int tdly, int st, int sw, int hd, int hz, int n, bit busy_start);
        exp_t e;
        int h;
        e.wr = wr;
        e.s = wr ? st + 1 : tdly + st + 2;
        e.len = sw + 1 + n;
        h = wr ? hd : hd + 1;
        e.d = e.s + e.len + h;
        if (wr && hz <= e.d - 1) begin
            e.first_oe = hz; e.n_oe = e.d - hz;
        end else begin
            e.first_oe = -1; e.n_oe = 0;
        end
        @(negedge clk);
        if (at) begin
            att_setup_i = TW'(st); att_strobe_i = TW'(sw); att_hold_i = TW'(hd); att_hiz_i = TW'(hz);
            com_setup_i = ~TW'(st); com_strobe_i = ~TW'(sw); com_hold_i = ~TW'(hd); com_hiz_i = ~TW'(hz);
        end else begin
            com_setup_i = TW'(st); com_strobe_i = TW'(sw); com_hold_i = TW'(hd); com_hiz_i = TW'(hz);
            att_setup_i = ~TW'(st); att_strobe_i = ~TW'(sw); att_hold_i = ~TW'(hd); att_hiz_i = ~TW'(hz);
        end
        turn_dly_i = TRW'(tdly);
        write_i = wr; attr_i = at; start_i = 1'b1; wait_n_i = 1'b1;
        q.push_back(e);
        @(posedge clk);
        acc_k = 0; active = 1'b1;
        @(negedge clk);
        // R2: scramble every timing input after the start edge
        if (!busy_start) start_i = 1'b0;
        write_i = ~write_i; attr_i = ~attr_i; turn_dly_i = ~turn_dly_i;
        com_setup_i = com_setup_i + 8'd3; com_strobe_i = com_strobe_i + 8'd5;
        com_hold_i = com_hold_i + 8'd7; com_hiz_i = com_hiz_i + 8'd9;
        att_setup_i = att_setup_i + 8'd3; att_strobe_i = att_strobe_i + 8'd5;
        att_hold_i = att_hold_i + 8'd7; att_hiz_i = att_hiz_i + 8'd9;
        forever begin
            if (acc_k >= e.s && ((n > 0) ? (acc_k <= e.s + sw + n - 1) : (acc_k < e.s + sw)))
                wait_n_i = 1'b0;
            else
                wait_n_i = 1'b1;
            @(posedge clk);
            acc_k++;
            if (acc_k > e.d) begin
                active = 1'b0;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        start_i = 1'b0; wait_n_i = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1", "we_n in reset", int'(we_n_o), 1);
        chk("R1", "oe_n in reset", int'(oe_n_o), 1);
        chk("R1", "data_oe in reset", int'(data_oe_o), 0);
        chk("R1", "done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after reset", int'({we_n_o, oe_n_o, data_oe_o, done_o}), 12);

        run_acc(1, 0, 0, 2, 3, 1, 2, 0, 0);      // R3 R7 R8 write, common
        run_acc(0, 0, 3, 1, 2, 0, 0, 0, 0);      // R4 read, one hold cycle
        run_acc(1, 1, 0, 0, 1, 0, 0, 3, 0);      // R6 stretch, R2 attribute set
        run_acc(0, 1, 5, 2, 4, 2, 9, 2, 0);      // R6 read stretch, R8 no drive on read
        run_acc(1, 0, 0, 0, 0, 0, 0, 0, 0);      // all-zero write
        run_acc(0, 0, 0, 0, 0, 0, 0, 0, 0);      // all-zero read
        run_acc(1, 1, 0, 3, 2, 1, 200, 0, 0);    // R8 release longer than access
        run_acc(1, 0, 0, 255, 255, 255, 255, 0, 0); // maximum counts
        run_acc(0, 1, 15, 255, 7, 3, 0, 1, 0);   // R4 maximum latch delay
        run_acc(1, 0, 0, 1, 2, 2, 1, 1, 1);      // R9 start held high through done
        repeat (20) @(negedge clk);
        chk("R9", "idle activity after ignored starts", idle_bad, 0);
        chk("R9", "accesses left pending", q.size(), 0);
        finish_run();
    end
endmodule